// File: doc/BRIEF.md
# Sub-Page MMIO Slot Dispatcher

The block sits behind one 4 KiB memory-mapped window and hands each access to one of several downstream peripheral ports. The window is cut into sixteen 256-byte slots. A small table, one entry per slot, records which port owns the slot. The upstream access is routed combinationally: the port that owns the addressed slot receives a select strobe, and its read data comes back to the upstream side in the same cycle.

The table is filled at run time through a mapping port. Each request names a byte offset, a byte length and a target id. The block writes that id into every slot that the byte range touches. A range that runs past the end of the window, or a target id with no port behind it, is refused: the error flag is raised and no table entry changes. Target id 0 is the built-in sink. Every slot holds it after reset. A slot that holds it gives zero on reads, and writes to it reach no port.

Top module: `mmio_subpage_dispatch`

## Requirements
- R1: The slot of an access is address bits [11:8]. At most one bit of `dn_sel` is high, and only while `up_valid` is high. Bit p is high when the slot holds target id p+1.
- R2: A mapping request with offset + length greater than 4096 raises `map_err` in the cycle after the request and leaves every slot unchanged.
- R3: An accepted request with nonzero length writes its target id into every slot from offset>>8 through (offset+length-1)>>8, inclusive. Other slots keep their ids. Accesses see the new owner from the cycle after the request.
- R4: After reset every slot holds target id 0.
- R5: An access to a slot holding id 0 asserts no `dn_sel` bit, and a read from it returns zero.
- R6: `up_addr` (the full in-window address), `up_size` (0 byte, 1 halfword, 2 word), `up_write` and `up_wdata` appear unchanged on `dn_addr`, `dn_size`, `dn_write` and `dn_wdata`.
- R7: A later request overrides earlier ids in the slots it covers.
- R8: A read returns the selected port's `dn_rdata` lane in the same cycle. Port p uses bits [32p+31:32p]. `up_rdata` is zero during writes and when idle.
- R9: A target id greater than the number of ports (4) is refused. `map_err` goes high the next cycle and no slot changes. A request with id 0 returns its slots to the sink.
- R10: A request with length zero and a legal target changes no slot and raises no error.
- R11: `map_err` is low in the cycle after any cycle with no request or with an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| up_valid | input | 1 | Upstream access strobe |
| up_write | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| up_addr | input | 12 | Byte address within the window |
| up_wdata | input | 32 | Write data |
| up_rdata | output | 32 | Read data, combinational |
| dn_sel | output | 4 | One select per downstream port |
| dn_write | output | 1 | Forwarded write flag |
| dn_size | output | 2 | Forwarded access size |
| dn_addr | output | 12 | Forwarded in-window address |
| dn_wdata | output | 32 | Forwarded write data |
| dn_rdata | input | 128 | Read data of all ports, 32 bits each |
| map_valid | input | 1 | Mapping request strobe |
| map_offset | input | 12 | First byte of the range |
| map_len | input | 13 | Range length in bytes |
| map_target | input | 3 | Target id: 0 sink, 1..4 port 0..3 |
| map_err | output | 1 | Request refused (registered) |

## Verification
Embedded properties check on every cycle that:
- the port select is one-hot or empty;
- sink slots neither select a port nor return data;
- writes return no read data;
- the table stays frozen after a refused request, after an idle cycle and after a zero-length request.

Only the bench's scenarios show that the table holds the right owner. These scenarios cover:
- slot coverage of ranges that straddle a slot boundary or end exactly at the window edge;
- overriding and unmapping;
- requests issued in the same cycle as an access, which must still be routed by the old owner.

// File: rtl/mmio_disp_pkg.sv
package mmio_disp_pkg;
  // access width code carried on up_size / dn_size
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  // id reserved for the built-in sink
  localparam int unsigned SINK_ID = 0;
endpackage

// File: rtl/mmio_rst_sync.sv
module mmio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/mmio_slot_table.sv
module mmio_slot_table #(
  parameter int PAGE_BITS = 12,
  parameter int SLOT_BITS = 8,
  parameter int N_PORTS   = 4,
  parameter int TID_W     = 3,
  localparam int IDX_W    = PAGE_BITS - SLOT_BITS,
  localparam int SLOTS    = 1 << IDX_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         map_valid,
  input  logic [PAGE_BITS-1:0]         map_offset,
  input  logic [PAGE_BITS:0]           map_len,
  input  logic [TID_W-1:0]             map_target,
  output logic                         map_err,
  output logic [SLOTS-1:0][TID_W-1:0]  slot_tid
);
  localparam int SUM_W = PAGE_BITS + 2;

  logic [SLOTS-1:0][TID_W-1:0] tid_q, tid_nxt;
  logic                        err_q, err_nxt;
  logic [SUM_W-1:0]            span_end, last_byte;
  logic                        range_bad, tgt_bad, reject, apply;
  logic [IDX_W-1:0]            first_idx, last_idx;

  // range arithmetic, widened so that offset + length cannot wrap
  assign span_end  = SUM_W'(map_offset) + SUM_W'(map_len);
  assign last_byte = span_end - SUM_W'(1);
  assign range_bad = span_end > (SUM_W'(1) << PAGE_BITS);
  assign tgt_bad   = map_target > TID_W'(N_PORTS);
  assign reject    = map_valid && (range_bad || tgt_bad);
  assign apply     = map_valid && !reject && (map_len != '0);
  assign first_idx = map_offset[PAGE_BITS-1:SLOT_BITS];
  assign last_idx  = last_byte[PAGE_BITS-1:SLOT_BITS];

  // each entry compares its own index against the range bounds
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic covered;
    assign covered = (IDX_W'(s) >= first_idx) && (IDX_W'(s) <= last_idx);
    always_comb begin
      tid_nxt[s] = tid_q[s];
      if (apply && covered) tid_nxt[s] = map_target;
    end
  end

  assign err_nxt = reject;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tid_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (apply) tid_q <= tid_nxt;
      err_q <= err_nxt;
    end
  end

  assign slot_tid = tid_q;
  assign map_err  = err_q;

  // a refused request must not have touched the table at that edge
  assert_refused_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    map_err |-> $stable(slot_tid));

  // no request, no change
  assert_idle_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !map_valid |=> ($stable(slot_tid) && !map_err));

  // zero length with a legal id is a no-op
  assert_empty_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (map_valid && map_len == '0 && map_target <= TID_W'(N_PORTS))
      |=> ($stable(slot_tid) && !map_err));
endmodule

// File: rtl/mmio_route.sv
module mmio_route
  import mmio_disp_pkg::*;
#(
  parameter int PAGE_BITS = 12,
  parameter int SLOT_BITS = 8,
  parameter int N_PORTS   = 4,
  parameter int TID_W     = 3,
  parameter int DATA_W    = 32,
  localparam int SLOTS    = 1 << (PAGE_BITS - SLOT_BITS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         up_valid,
  input  logic                         up_write,
  input  logic [1:0]                   up_size,
  input  logic [PAGE_BITS-1:0]         up_addr,
  input  logic [DATA_W-1:0]            up_wdata,
  output logic [DATA_W-1:0]            up_rdata,
  input  logic [SLOTS-1:0][TID_W-1:0]  slot_tid,
  output logic [N_PORTS-1:0]           dn_sel,
  output logic                         dn_write,
  output logic [1:0]                   dn_size,
  output logic [PAGE_BITS-1:0]         dn_addr,
  output logic [DATA_W-1:0]            dn_wdata,
  input  logic [N_PORTS*DATA_W-1:0]    dn_rdata
);
  logic [TID_W-1:0]  cur_tid;
  logic [DATA_W-1:0] rd_mux;

  assign cur_tid = slot_tid[up_addr[PAGE_BITS-1:SLOT_BITS]];

  for (genvar p = 0; p < N_PORTS; p++) begin : g_sel
    assign dn_sel[p] = up_valid && (cur_tid == TID_W'(p + 1));
  end

  // read return: select-driven mux, zero when nothing is read
  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (dn_sel[p] && !up_write) rd_mux = dn_rdata[p*DATA_W +: DATA_W];
    end
  end

  assign up_rdata = rd_mux;
  assign dn_write = up_write;
  assign dn_size  = up_size;
  assign dn_addr  = up_addr;
  assign dn_wdata = up_wdata;

  assert_single_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_sel) && (up_valid || dn_sel == '0));

  assert_sink_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && cur_tid == TID_W'(SINK_ID)) |-> (dn_sel == '0 && up_rdata == '0));

  assert_write_no_rdata_R8: assert property (@(posedge clk) disable iff (!rst_n)
    up_write |-> (up_rdata == '0));
endmodule

// File: rtl/mmio_subpage_dispatch.sv
module mmio_subpage_dispatch #(
  parameter int PAGE_BITS = 12,
  parameter int SLOT_BITS = 8,
  parameter int N_PORTS   = 4,
  parameter int DATA_W    = 32,
  localparam int TID_W    = $clog2(N_PORTS + 1),
  localparam int SLOTS    = 1 << (PAGE_BITS - SLOT_BITS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       up_valid,
  input  logic                       up_write,
  input  logic [1:0]                 up_size,
  input  logic [PAGE_BITS-1:0]       up_addr,
  input  logic [DATA_W-1:0]          up_wdata,
  output logic [DATA_W-1:0]          up_rdata,
  output logic [N_PORTS-1:0]         dn_sel,
  output logic                       dn_write,
  output logic [1:0]                 dn_size,
  output logic [PAGE_BITS-1:0]       dn_addr,
  output logic [DATA_W-1:0]          dn_wdata,
  input  logic [N_PORTS*DATA_W-1:0]  dn_rdata,
  input  logic                       map_valid,
  input  logic [PAGE_BITS-1:0]       map_offset,
  input  logic [PAGE_BITS:0]         map_len,
  input  logic [TID_W-1:0]           map_target,
  output logic                       map_err
);
  logic                        rst_n_sync;
  logic [SLOTS-1:0][TID_W-1:0] slot_tid;

  mmio_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  mmio_slot_table #(
    .PAGE_BITS (PAGE_BITS),
    .SLOT_BITS (SLOT_BITS),
    .N_PORTS   (N_PORTS),
    .TID_W     (TID_W)
  ) i_table (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .map_valid  (map_valid),
    .map_offset (map_offset),
    .map_len    (map_len),
    .map_target (map_target),
    .map_err    (map_err),
    .slot_tid   (slot_tid)
  );

  mmio_route #(
    .PAGE_BITS (PAGE_BITS),
    .SLOT_BITS (SLOT_BITS),
    .N_PORTS   (N_PORTS),
    .TID_W     (TID_W),
    .DATA_W    (DATA_W)
  ) i_route (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .up_valid (up_valid),
    .up_write (up_write),
    .up_size  (up_size),
    .up_addr  (up_addr),
    .up_wdata (up_wdata),
    .up_rdata (up_rdata),
    .slot_tid (slot_tid),
    .dn_sel   (dn_sel),
    .dn_write (dn_write),
    .dn_size  (dn_size),
    .dn_addr  (dn_addr),
    .dn_wdata (dn_wdata),
    .dn_rdata (dn_rdata)
  );
endmodule

// File: tb/test_mmio_subpage_dispatch.sv
module test_mmio_subpage_dispatch;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        up_valid, up_write;
  logic [1:0]  up_size;
  logic [11:0] up_addr;
  logic [31:0] up_wdata, up_rdata;
  logic [3:0]  dn_sel;
  logic        dn_write;
  logic [1:0]  dn_size;
  logic [11:0] dn_addr;
  logic [31:0] dn_wdata;
  logic [127:0] dn_rdata;
  logic        map_valid;
  logic [11:0] map_offset;
  logic [12:0] map_len;
  logic [2:0]  map_target;
  logic        map_err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int mtid[16];
  bit exp_err = 0;

  always #5 clk = ~clk;

  // each port answers with its own tag and the forwarded address
  for (genvar k = 0; k < 4; k++) begin : g_port
    assign dn_rdata[k*32 +: 32] = {8'(8'hD0 + k), 12'h000, dn_addr};
  end

  mmio_subpage_dispatch i_mmio_subpage_dispatch (
    .clk(clk), .rst_n(rst_n),
    .up_valid(up_valid), .up_write(up_write), .up_size(up_size),
    .up_addr(up_addr), .up_wdata(up_wdata), .up_rdata(up_rdata),
    .dn_sel(dn_sel), .dn_write(dn_write), .dn_size(dn_size),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata),
    .map_valid(map_valid), .map_offset(map_offset), .map_len(map_len),
    .map_target(map_target), .map_err(map_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: check combinational outputs, clock, update model, check error flag
  task automatic step();
    int t;
    logic [3:0]  exp_sel;
    logic [31:0] exp_rd;
    #1;
    t = mtid[up_addr[11:8]];
    exp_sel = (up_valid && t != 0) ? 4'(1 << (t - 1)) : 4'h0;
    exp_rd  = (up_valid && !up_write && t != 0) ? {8'(8'hD0 + t - 1), 12'h000, up_addr} : 32'h0;
    chk(dn_sel == exp_sel, (t == 0) ? "R5 sink select" : "R1 port select", 32'(dn_sel), 32'(exp_sel));
    chk(up_rdata == exp_rd, (t == 0) ? "R5 sink read" : "R8 read data", up_rdata, exp_rd);
    chk(dn_addr == up_addr && dn_size == up_size && dn_wdata == up_wdata && dn_write == up_write,
        "R6 forwarding", {dn_write, dn_size, dn_addr, 17'h0}, {up_write, up_size, up_addr, 17'h0});
    @(posedge clk);
    exp_err = 0;
    if (map_valid) begin
      int e;
      e = int'(map_offset) + int'(map_len);
      if (e > 4096 || map_target > 3'd4) exp_err = 1;
      else if (map_len != 0)
        for (int i = int'(map_offset) / 256; i <= (e - 1) / 256; i++) mtid[i] = int'(map_target);
    end
    #1;
    chk(map_err == exp_err, "R2 R9 R11 error flag", 32'(map_err), 32'(exp_err));
    @(negedge clk);
  endtask

  task automatic access(input bit w, input logic [1:0] sz, input logic [11:0] a, input logic [31:0] d);
    up_valid = 1; up_write = w; up_size = sz; up_addr = a; up_wdata = d;
    step();
    up_valid = 0; up_write = 0;
  endtask

  task automatic map(input int off, input int len, input int tgt);
    map_valid = 1; map_offset = 12'(off); map_len = 13'(len); map_target = 3'(tgt);
    step();
    map_valid = 0;
  endtask

  task automatic read_all_slots();
    for (int s = 0; s < 16; s++) access(0, 2'd2, 12'(s * 256 + 8'h3C), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mtid[i] = 0;
    rst_n = 0; up_valid = 0; up_write = 0; up_size = 0; up_addr = 0; up_wdata = 0;
    map_valid = 0; map_offset = 0; map_len = 0; map_target = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);

    // R4: every slot is sink after reset
    #1 chk(map_err == 0, "R4 reset error flag", 32'(map_err), 0);
    @(negedge clk);
    read_all_slots();

    // R3: single slot, then a range straddling slots 1 and 2
    map(12'h000, 256, 1);
    access(0, 2'd0, 12'h0FF, 0);
    access(0, 2'd1, 12'h100, 0);
    map(12'h1F0, 32, 2);
    access(0, 2'd2, 12'h1FC, 0);
    access(1, 2'd2, 12'h200, 32'hCAFEF00D);
    access(0, 2'd2, 12'h2FC, 0);
    access(0, 2'd2, 12'h300, 0);
    // exact fit at the window end accepted
    map(12'hF00, 256, 4);
    access(0, 2'd2, 12'hFFC, 0);
    // R2: one byte past the end refused
    map(12'hF01, 256, 3);
    read_all_slots();
    map(0, 4096 + 1, 3);
    // R9: id beyond the port count refused
    map(12'h400, 256, 5);
    map(12'h400, 256, 7);
    access(0, 2'd2, 12'h400, 0);
    // R10: zero length no-op
    map(12'h500, 0, 3);
    access(0, 2'd2, 12'h500, 0);
    // R7: override, R9: unmap with id 0
    map(12'h000, 1024, 3);
    read_all_slots();
    map(12'h100, 1, 0);
    access(0, 2'd2, 12'h180, 0);
    // whole window at once
    map(0, 4096, 2);
    read_all_slots();

    // mixed traffic with requests in the same cycle as accesses
    for (int n = 0; n < 400; n++) begin
      up_valid  = ($urandom % 4) != 0;
      up_write  = $urandom % 2;
      up_size   = 2'($urandom % 3);
      up_addr   = 12'($urandom);
      up_wdata  = $urandom;
      map_valid = ($urandom % 3) == 0;
      map_offset = 12'($urandom);
      map_len   = ($urandom % 5 == 0) ? 13'($urandom % 8192) : 13'($urandom % 700);
      map_target = 3'($urandom % 6);
      step();
    end
    up_valid = 0; map_valid = 0;
    read_all_slots();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule